// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block gives a host a way to reach a small bank of 8-bit configuration registers through three adjacent I/O port addresses. The lowest of the three is a gate port: the bank can only be reached after the host writes a fixed key byte there. Writing zero to the gate port closes the bank again. While the bank is open, the host writes a register number to the middle port. It then reads or writes that register through the top port.

The contents of every register are driven out in parallel, so that neighbouring logic can decode them. One register, chosen by a parameter, also has its two low bits brought out as a power-mode code. The bus is a plain strobe interface. Reads are combinational: the data appears in the same cycle as the read strobe.

Top module: `cfg_keyport`

## Requirements
- R1: After reset the port is locked, the selected index is 0, and all 16 registers and the power-mode output read 0.
- R2: A write of 8'h89 to the gate port (address BASE) opens the bank from the next cycle.
- R3: A write of 8'h00 to the gate port closes the bank from the next cycle.
- R4: A write to the gate port of any value other than 8'h89 or 8'h00 leaves the lock state unchanged.
- R5: While the bank is locked, writes to the index port and the data port change nothing, and reads of the index port or the data port return 8'hFF.
- R6: While the bank is open, a write to the index port (BASE+1) selects a register. A read of the index port returns the stored index.
- R7: While the bank is open and the index is below 16, a write to the data port (BASE+2) stores the byte in the selected register. The new value appears on `cfg_regs` (register n at bits 8n+7:8n) one cycle later.
- R8: While the bank is open, a read of the data port returns the selected register's current contents in the same cycle as the read strobe.
- R9: An index of 16 or more makes data-port writes have no effect and data-port reads return 8'hFF.
- R10: `pwr_mode` equals bits 1:0 of register PM_IDX (default 2). Code 2'b11 means automatic power-down and 2'b10 means standby for automatic power-down.
- R11: Reads of the gate port, reads of any address outside BASE..BASE+2, and cycles with no read strobe return 8'hFF. Writes outside that window change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (10) | Port address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| cfg_regs | output | NREG*8 (128) | All register contents, register n in bits 8n+7:8n |
| pwr_mode | output | 2 | Low two bits of register PM_IDX |

## Verification
The embedded properties assume that each strobe is one full clock cycle wide and that address and data are stable for the whole cycle the strobe is high. They also treat a cycle with both strobes high as a read of the old contents followed by a write. The stimulus changes inputs only at falling edges and holds them through the rising edge. It mixes directed sequences with random cycles whose addresses are biased toward the three ports and whose data is biased toward the key, zero and small index values, so that both the locked and the open paths are exercised repeatedly.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;

  localparam logic [7:0] KEY_OPEN  = 8'h89;
  localparam logic [7:0] KEY_CLOSE = 8'h00;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    PS_NONE = 2'd0,
    PS_GATE = 2'd1,
    PS_IDX  = 2'd2,
    PS_DAT  = 2'd3
  } port_sel_e;

  typedef enum logic [1:0] {
    PM_RUN     = 2'b00,
    PM_IMMED   = 2'b01,
    PM_STANDBY = 2'b10,
    PM_AUTO    = 2'b11
  } pwr_mode_e;

  function automatic port_sel_e decode_port(input logic [15:0] addr,
                                            input logic [15:0] base);
    logic [15:0] off;
    off = addr - base;
    if (addr < base)        return PS_NONE;
    else if (off == 16'd0)  return PS_GATE;
    else if (off == 16'd1)  return PS_IDX;
    else if (off == 16'd2)  return PS_DAT;
    else                    return PS_NONE;
  endfunction

  function automatic logic index_ok(input logic [7:0] idx, input logic [7:0] depth);
    return idx < depth;
  endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfg_keyport_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h250
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              gate_wr_o,
  output logic              idx_wr_o,
  output logic              dat_wr_o,
  output logic              idx_rd_o,
  output logic              dat_rd_o
);
  localparam logic [15:0] BASE16 = 16'(BASE);

  port_sel_e sel;

  always_comb begin
    sel = decode_port(16'(addr_i), BASE16);
  end

  assign gate_wr_o = wr_i && (sel == PS_GATE);
  assign idx_wr_o  = wr_i && (sel == PS_IDX);
  assign dat_wr_o  = wr_i && (sel == PS_DAT);
  assign idx_rd_o  = rd_i && (sel == PS_IDX);
  assign dat_rd_o  = rd_i && (sel == PS_DAT);

endmodule

// File: rtl/cfgp_lock.sv
module cfgp_lock
  import cfg_keyport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  logic open_ev;
  logic close_ev;

  assign open_ev  = gate_wr_i && (wdata_i == KEY_OPEN);
  assign close_ev = gate_wr_i && (wdata_i == KEY_CLOSE);

  always_ff @(posedge clk) begin
    if (!rst_n)        open_o <= 1'b0;
    else if (open_ev)  open_o <= 1'b1;
    else if (close_ev) open_o <= 1'b0;
  end

  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_ev |=> open_o);

  // R3
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_ev |=> !open_o);

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_ev && !close_ev) |=> $stable(open_o));

endmodule

// File: rtl/cfgp_index.sv
module cfgp_index
  import cfg_keyport_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr_i,
  input  logic       open_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] idx_o,
  output logic       idx_ok_o
);
  localparam logic [7:0] DEPTH = 8'(NREG);

  logic idx_load;

  assign idx_load = idx_wr_i && open_i;

  always_ff @(posedge clk) begin
    if (!rst_n)        idx_o <= 8'h00;
    else if (idx_load) idx_o <= wdata_i;
  end

  assign idx_ok_o = index_ok(idx_o, DEPTH);

  // R5
  idx_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_i |=> $stable(idx_o));

  // R6
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> idx_o == $past(wdata_i));

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile #(
  parameter int NREG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [7:0]        wdata_i,
  output logic [NREG*8-1:0] flat_o
);
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [7:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (sel_i == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   mem[g] <= 8'h00;
      else if (hit) mem[g] <= wdata_i;
    end
    assign flat_o[g*8 +: 8] = mem[g];
  end

  // R7
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> flat_o[$past(sel_i)*8 +: 8] == $past(wdata_i));

  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(flat_o));

endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
  import cfg_keyport_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h250,
  parameter int NREG   = 16,
  parameter int PM_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [NREG*8-1:0] cfg_regs,
  output logic [1:0]        pwr_mode
);
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic       gate_wr, idx_wr, dat_wr, idx_rd, dat_rd;
  logic       bank_open;
  logic [7:0] idx_q;
  logic       idx_ok;
  logic       store_ev;
  logic [SEL_W-1:0] sel;
  logic [7:0] sel_byte;

  cfgp_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr_i(bus_addr), .wr_i(bus_wr), .rd_i(bus_rd),
    .gate_wr_o(gate_wr), .idx_wr_o(idx_wr), .dat_wr_o(dat_wr),
    .idx_rd_o(idx_rd), .dat_rd_o(dat_rd)
  );

  cfgp_lock u_lock (
    .clk(clk), .rst_n(rst_n), .gate_wr_i(gate_wr), .wdata_i(bus_wdata),
    .open_o(bank_open)
  );

  cfgp_index #(.NREG(NREG)) u_idx (
    .clk(clk), .rst_n(rst_n), .idx_wr_i(idx_wr), .open_i(bank_open),
    .wdata_i(bus_wdata), .idx_o(idx_q), .idx_ok_o(idx_ok)
  );

  assign store_ev = dat_wr && bank_open && idx_ok;
  assign sel      = idx_q[SEL_W-1:0];

  cfgp_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we_i(store_ev), .sel_i(sel),
    .wdata_i(bus_wdata), .flat_o(cfg_regs)
  );

  assign sel_byte = cfg_regs[sel*8 +: 8];

  always_comb begin
    bus_rdata = IDLE_BYTE;
    if (bank_open) begin
      if (dat_rd && idx_ok) bus_rdata = sel_byte;
      else if (idx_rd)      bus_rdata = idx_q;
    end
  end

  assign pwr_mode = cfg_regs[PM_IDX*8 +: 2];

  // R5
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_open && bus_rd) |-> bus_rdata == IDLE_BYTE);

  // R9
  range_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idx_ok) |=> $stable(cfg_regs));

  // R11
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_rd && !dat_rd) |-> bus_rdata == IDLE_BYTE);

endmodule

// File: tb/tb_cfg_keyport.sv
module tb_cfg_keyport;

  localparam int BASE = 'h250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [127:0] cfg_regs;
  logic [1:0]  pwr_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference model
  bit       m_open;
  int       m_idx;
  int       m_reg [16];

  always #10 clk = ~clk;

  cfg_keyport dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_regs(cfg_regs), .pwr_mode(pwr_mode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_read(input int a);
    if (a == BASE + 2) return (m_open && m_idx < 16) ? m_reg[m_idx] : 'hFF;
    if (a == BASE + 1) return m_open ? m_idx : 'hFF;
    return 'hFF;
  endfunction

  task automatic compare_state(input string tag);
    for (int i = 0; i < 16; i++) check(tag, int'(cfg_regs[i*8 +: 8]), m_reg[i]);
    check("R10", int'(pwr_mode), m_reg[2] & 3);
  endtask

  task automatic op(input int a, input bit w, input bit r, input int d, input string tag);
    @(negedge clk);
    bus_addr = 10'(a); bus_wr = w; bus_rd = r; bus_wdata = 8'(d);
    #2;
    if (r) check(tag, int'(bus_rdata), model_read(a));
    else   check("R11", int'(bus_rdata), 'hFF);
    @(posedge clk);
    if (w) begin
      if (a == BASE) begin
        if (d == 'h89) m_open = 1;
        else if (d == 0) m_open = 0;
      end else if (a == BASE + 1 && m_open) m_idx = d;
      else if (a == BASE + 2 && m_open && m_idx < 16) m_reg[m_idx] = d;
    end
    #5;
    bus_wr = 0; bus_rd = 0;
    compare_state(tag);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_open = 0; m_idx = 0;
    for (int i = 0; i < 16; i++) m_reg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    compare_state("R1");
    op(BASE + 2, 0, 1, 0, "R1");
    // R5 locked accesses
    op(BASE + 1, 1, 0, 3, "R5");
    op(BASE + 2, 1, 0, 'h5A, "R5");
    op(BASE + 1, 0, 1, 0, "R5");
    // R4 wrong key stays locked
    op(BASE, 1, 0, 'h88, "R4");
    op(BASE + 2, 0, 1, 0, "R4");
    // R2 unlock
    op(BASE, 1, 0, 'h89, "R2");
    op(BASE + 1, 0, 1, 0, "R2");
    // R4 other value keeps open
    op(BASE, 1, 0, 'h33, "R4");
    op(BASE + 1, 0, 1, 0, "R4");
    // R6, R7, R8
    op(BASE + 1, 1, 0, 5, "R6");
    op(BASE + 1, 0, 1, 0, "R6");
    op(BASE + 2, 1, 0, 'hC4, "R7");
    op(BASE + 2, 0, 1, 0, "R8");
    op(BASE + 1, 1, 0, 15, "R7");
    op(BASE + 2, 1, 1, 'h7E, "R8");
    op(BASE + 2, 0, 1, 0, "R8");
    // R10 power mode codes
    op(BASE + 1, 1, 0, 2, "R10");
    op(BASE + 2, 1, 0, 'h3B, "R10");
    check("R10", int'(pwr_mode), 2'b11);
    op(BASE + 2, 1, 0, 'h3A, "R10");
    check("R10", int'(pwr_mode), 2'b10);
    // R9 out of range index
    op(BASE + 1, 1, 0, 16, "R9");
    op(BASE + 2, 1, 0, 'h11, "R9");
    op(BASE + 2, 0, 1, 0, "R9");
    op(BASE + 1, 1, 0, 'hFE, "R9");
    op(BASE + 2, 0, 1, 0, "R9");
    // R11 other addresses and gate read
    op(BASE, 0, 1, 0, "R11");
    op(BASE + 3, 1, 1, 'h89, "R11");
    op(BASE - 1, 1, 1, 0, "R11");
    // R3 relock
    op(BASE + 1, 1, 0, 2, "R3");
    op(BASE, 1, 0, 0, "R3");
    op(BASE + 2, 0, 1, 0, "R3");
    op(BASE + 2, 1, 0, 'h99, "R3");
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int sel, a, d;
      sel = $urandom_range(0, 9);
      a = (sel < 8) ? BASE + (sel % 3) : $urandom_range(0, 1023);
      case ($urandom_range(0, 3))
        0: d = 'h89;
        1: d = 0;
        2: d = $urandom_range(0, 20);
        default: d = $urandom_range(0, 255);
      endcase
      op(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), d, "R7");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule